// File: doc/BRIEF.md
# YCbCr 4:2:2 Output Format Selector

This block sits at the output of a video pipeline whose luma and chroma have been processed on separate 4:2:2 streams. Each clock it takes one luma sample, one chroma sample and the horizontal and vertical sync. It drives them out in one of two forms. The first is a 16-bit pair: luma on the Y bus, with Cb and Cr alternating on the chroma bus. The second is an 8-bit stream on the Y bus alone, in the order chroma, luma, chroma, luma. In the 8-bit form the chroma bus is released through an output-enable pin, and the tri-state buffer sits at the pad level.

Three control inputs pick the format. The first says the upstream input was byte-wide. The second says it was a serial stream with embedded timing codes, whose recovered syncs are supplied on the sync inputs. The third asks for byte output. A delay line adds a fixed, mode-dependent latency that is identical for the data and the syncs.

A mode state machine has three named states: WIDE (16-bit in, 16-bit out), BYTE_IN (narrow in, 16-bit out) and BYTE_OUT (narrow in, 8-bit out). On a rising vertical sync, every state moves to the state decoded from the control inputs. At all other times it holds. A phase state machine cycles PH_CB → PH_Y0 → PH_CR → PH_Y1 → PH_CB, and from any state it jumps to PH_CB on a rising horizontal sync.

Top module: `ycc_out_formatter`

## Requirements
- R1: In the WIDE and BYTE_IN modes, `yo` carries the luma input, `co` carries the chroma input and `co_oe` is 1.
- R2: BYTE_OUT is entered only when `out_byte_req` is 1 and either `in_byte` or `in_embedded` is 1. With both input bits at 0 the mode is WIDE, whatever `out_byte_req` is. With a narrow input and the request at 0, the mode is BYTE_IN.
- R3: In BYTE_OUT, `co_oe` is 0 and `co` is driven to all zeros.
- R4: In BYTE_OUT, `yo` carries the chroma input on phases 0 and 2 and the luma input on phases 1 and 3. The phase is 0 for the sample on which `hs_in` rises, and it advances by one (mod 4) on every other clock.
- R5: In WIDE, a sample captured at a clock edge appears on the outputs just after the 32nd edge, counting the capture edge as the first.
- R6: In BYTE_IN, the latency counted the same way is 64 edges.
- R7: In BYTE_OUT, the latency counted the same way is 66 edges.
- R8: After reset the mode is WIDE, and all data and sync outputs are 0. A change on the control inputs takes effect only at the clock edge where `vs_in` is 1 and was 0 on the previous edge.
- R9: `ohs` and `ovs` follow `hs_in` and `vs_in` with the same latency as the data in every mode, including the embedded-timing input case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| y_in | input | 8 | Luma sample |
| c_in | input | 8 | Chroma sample, Cb and Cr alternating |
| hs_in | input | 1 | Horizontal sync, rising edge starts a line |
| vs_in | input | 1 | Vertical sync, rising edge applies the mode |
| in_byte | input | 1 | Upstream input was byte-wide |
| in_embedded | input | 1 | Upstream input carried embedded timing codes |
| out_byte_req | input | 1 | Request for 8-bit output |
| yo | output | 8 | Luma bus, or the interleaved stream in byte mode |
| co | output | 8 | Chroma bus, zero when released |
| co_oe | output | 1 | Output enable for the chroma bus pads |
| ohs | output | 1 | Delayed horizontal sync |
| ovs | output | 1 | Delayed vertical sync |

## Verification
The bench measures each of the three latencies to the exact clock edge. It checks that the sync is still low one cycle before the expected edge and high at it. A tap off by one in any mode therefore fails, and so does a sync path that is not aligned with the data. It runs byte-output lines that start after an even and after an odd number of idle cycles. A phase counter that is not restarted by the line sync then swaps chroma and luma on one of the two runs. It also changes the control bits without a vertical-sync edge, and asks for byte output while the input is wide. A mode register that reacts early, or that does not qualify the request, then shows the wrong enable and the wrong latency.

// File: rtl/ycc_fmt_pkg.sv
package ycc_fmt_pkg;
    parameter int unsigned PIX_W = 8;

    typedef enum logic [1:0] {
        MODE_WIDE     = 2'd0,
        MODE_BYTE_IN  = 2'd1,
        MODE_BYTE_OUT = 2'd2
    } fmt_mode_e;

    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } pair_phase_e;

    typedef struct packed {
        logic [PIX_W-1:0] yo;
        logic [PIX_W-1:0] co;
        logic             hs;
        logic             vs;
    } out_word_t;
endpackage

// File: rtl/ycc_mode_ctrl.sv
module ycc_mode_ctrl
    import ycc_fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vs_in,
    input  logic      in_byte,
    input  logic      in_embedded,
    input  logic      out_byte_req,
    output fmt_mode_e mode_q
);
    logic      vs_prev;
    logic      vs_rise;
    fmt_mode_e mode_d;
    fmt_mode_e mode_req;

    assign vs_rise = vs_in & ~vs_prev;

    // decode of the requested format, qualified by the input width
    always_comb begin
        unique case ({in_byte | in_embedded, out_byte_req})
            2'b10:   mode_req = MODE_BYTE_IN;
            2'b11:   mode_req = MODE_BYTE_OUT;
            default: mode_req = MODE_WIDE;
        endcase
    end

    // every state moves to the requested one on a vsync rise, else holds
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_WIDE:     if (vs_rise) mode_d = mode_req;
            MODE_BYTE_IN:  if (vs_rise) mode_d = mode_req;
            MODE_BYTE_OUT: if (vs_rise) mode_d = mode_req;
            default:       mode_d = MODE_WIDE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_WIDE;
            vs_prev <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            vs_prev <= vs_in;
        end
    end

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> $stable(mode_q));

    assert_wide_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise && !in_byte && !in_embedded) |=> (mode_q == MODE_WIDE));
endmodule

// File: rtl/ycc_pair_sequencer.sv
module ycc_pair_sequencer
    import ycc_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] y_in,
    input  logic [PIX_W-1:0] c_in,
    input  logic             hs_in,
    input  logic             vs_in,
    input  logic             byte_out,
    output out_word_t        word
);
    logic        hs_prev;
    logic        hs_rise;
    pair_phase_e phase_q;
    pair_phase_e phase_now;
    pair_phase_e phase_d;

    assign hs_rise   = hs_in & ~hs_prev;
    assign phase_now = hs_rise ? PH_CB : phase_q;

    always_comb begin
        unique case (phase_now)
            PH_CB: phase_d = PH_Y0;
            PH_Y0: phase_d = PH_CR;
            PH_CR: phase_d = PH_Y1;
            PH_Y1: phase_d = PH_CB;
            default: phase_d = PH_CB;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CB;
            hs_prev <= 1'b0;
        end else begin
            phase_q <= phase_d;
            hs_prev <= hs_in;
        end
    end

    // output process: pick the sample presented on the luma bus
    always_comb begin
        word.co = c_in;
        word.hs = hs_in;
        word.vs = vs_in;
        word.yo = y_in;
        if (byte_out) begin
            unique case (phase_now)
                PH_CB, PH_CR: word.yo = c_in;
                PH_Y0, PH_Y1: word.yo = y_in;
                default:      word.yo = y_in;
            endcase
        end
    end

    assert_phase_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> (phase_q == PH_Y0));

    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_rise |=> (2'(phase_q) == 2'($past(phase_q) + 2'd1)));
endmodule

// File: rtl/ycc_align_delay.sv
module ycc_align_delay
    import ycc_fmt_pkg::*;
#(
    parameter int unsigned LAT_WIDE     = 32,
    parameter int unsigned LAT_BYTE_IN  = 64,
    parameter int unsigned LAT_BYTE_OUT = 66
) (
    input  logic      clk,
    input  logic      rst_n,
    input  fmt_mode_e mode,
    input  out_word_t word,
    output out_word_t tap
);
    localparam int unsigned MAX_A = (LAT_WIDE > LAT_BYTE_IN) ? LAT_WIDE : LAT_BYTE_IN;
    localparam int unsigned DEPTH = (MAX_A > LAT_BYTE_OUT) ? MAX_A : LAT_BYTE_OUT;
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    out_word_t        line_q [DEPTH];
    logic [IDX_W-1:0] tap_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
        end else begin
            line_q[0] <= word;
            for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
        end
    end

    always_comb begin
        unique case (mode)
            MODE_BYTE_IN:  tap_idx = IDX_W'(LAT_BYTE_IN - 1);
            MODE_BYTE_OUT: tap_idx = IDX_W'(LAT_BYTE_OUT - 1);
            default:       tap_idx = IDX_W'(LAT_WIDE - 1);
        endcase
    end

    assign tap = line_q[tap_idx];

    // the two narrow-input taps are two stages apart
    assert_narrow_taps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (line_q[LAT_BYTE_OUT-1] == $past(line_q[LAT_BYTE_IN-1], 2)));
endmodule

// File: rtl/ycc_out_formatter.sv
module ycc_out_formatter
    import ycc_fmt_pkg::*;
#(
    parameter int unsigned LAT_WIDE     = 32,
    parameter int unsigned LAT_BYTE_IN  = 64,
    parameter int unsigned LAT_BYTE_OUT = 66
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] y_in,
    input  logic [PIX_W-1:0] c_in,
    input  logic             hs_in,
    input  logic             vs_in,
    input  logic             in_byte,
    input  logic             in_embedded,
    input  logic             out_byte_req,
    output logic [PIX_W-1:0] yo,
    output logic [PIX_W-1:0] co,
    output logic             co_oe,
    output logic             ohs,
    output logic             ovs
);
    fmt_mode_e mode_q;
    out_word_t word;
    out_word_t tap;
    logic      byte_out;

    ycc_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .vs_in       (vs_in),
        .in_byte     (in_byte),
        .in_embedded (in_embedded),
        .out_byte_req(out_byte_req),
        .mode_q      (mode_q)
    );

    assign byte_out = (mode_q == MODE_BYTE_OUT);

    ycc_pair_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .y_in    (y_in),
        .c_in    (c_in),
        .hs_in   (hs_in),
        .vs_in   (vs_in),
        .byte_out(byte_out),
        .word    (word)
    );

    ycc_align_delay #(
        .LAT_WIDE    (LAT_WIDE),
        .LAT_BYTE_IN (LAT_BYTE_IN),
        .LAT_BYTE_OUT(LAT_BYTE_OUT)
    ) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode_q),
        .word (word),
        .tap  (tap)
    );

    assign co_oe = ~byte_out;
    assign co    = co_oe ? tap.co : '0;
    assign yo    = tap.yo;
    assign ohs   = tap.hs;
    assign ovs   = tap.vs;
endmodule

// File: tb/ycc_out_formatter_tb.sv
`timescale 1ns/1ps
module ycc_out_formatter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] y_in = '0, c_in = '0;
    logic       hs_in = 1'b0, vs_in = 1'b0;
    logic       in_byte = 1'b0, in_embedded = 1'b0, out_byte_req = 1'b0;
    logic [7:0] yo, co;
    logic       co_oe, ohs, ovs;

    int checks = 0;
    int errors = 0;
    logic [7:0] base = 8'h10;

    always #4 clk = ~clk;

    ycc_out_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .y_in(y_in), .c_in(c_in),
        .hs_in(hs_in), .vs_in(vs_in), .in_byte(in_byte),
        .in_embedded(in_embedded), .out_byte_req(out_byte_req),
        .yo(yo), .co(co), .co_oe(co_oe), .ohs(ohs), .ovs(ovs)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        y_in = '0; c_in = '0; hs_in = 1'b0; vs_in = 1'b0;
    endtask

    // apply control bits, pulse vsync, measure ovs latency and enable
    task automatic set_mode(input logic b, input logic e, input logic r,
                            input int lat, input logic exp_oe, input string tag);
        repeat (70) idle();
        in_byte = b; in_embedded = e; out_byte_req = r;
        for (int t = 0; t <= lat; t++) begin
            @(negedge clk);
            if (t == 1)       check({tag, " co_oe after vsync"}, co_oe, exp_oe);
            if (t == lat - 1) check("R9 ovs not early", ovs, 0);
            if (t == lat)     check("R9 ovs at latency", ovs, 1);
            vs_in = (t == 0);
        end
        idle();
    endtask

    // one short line after pre idle cycles, checked sample by sample
    task automatic run_line(input int lat, input logic byte_mode, input int pre,
                            input string tag);
        localparam int N = 8;
        for (int p = 0; p < pre; p++) idle();
        for (int t = 0; t < lat + N; t++) begin
            @(negedge clk);
            if (t == lat - 1) check({tag, " ohs not early"}, ohs, 0);
            if (t >= lat) begin
                int s;
                logic [7:0] ys, cs;
                s  = t - lat;
                ys = base + 8'(s);
                cs = base + 8'h80 + 8'(s);
                check({tag, " ohs"}, ohs, (s == 0) ? 1 : 0);
                if (byte_mode) begin
                    check("R4 byte order", yo, (s % 2 == 0) ? cs : ys);
                    check("R3 co_oe", co_oe, 0);
                    check("R3 co zero", co, 0);
                end else begin
                    check("R1 luma", yo, ys);
                    check("R1 chroma", co, cs);
                    check("R1 co_oe", co_oe, 1);
                end
            end
            if (t < N) begin
                y_in  = base + 8'(t);
                c_in  = base + 8'h80 + 8'(t);
                hs_in = (t == 0);
            end else begin
                y_in = '0; c_in = '0; hs_in = 1'b0;
            end
        end
        idle();
        base = base + 8'h08;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset yo", yo, 0);
        check("R8 reset co", co, 0);
        check("R8 reset co_oe", co_oe, 1);
        check("R8 reset ohs", ohs, 0);
        check("R8 reset ovs", ovs, 0);

        run_line(32, 1'b0, 0, "R5 wide");
        // byte request with wide input is not honoured
        set_mode(1'b0, 1'b0, 1'b1, 32, 1'b1, "R2 wide qual");
        run_line(32, 1'b0, 1, "R2 wide");
        set_mode(1'b1, 1'b0, 1'b0, 64, 1'b1, "R6 byte in");
        run_line(64, 1'b0, 0, "R6 byte in");
        // request changes without vsync: no effect
        out_byte_req = 1'b1;
        repeat (5) idle();
        check("R8 no change without vsync", co_oe, 1);
        run_line(64, 1'b0, 0, "R8 held");
        set_mode(1'b1, 1'b0, 1'b1, 66, 1'b0, "R3 byte out");
        run_line(66, 1'b1, 0, "R7 byte out");
        run_line(66, 1'b1, 1, "R7 byte out odd");
        set_mode(1'b0, 1'b1, 1'b1, 66, 1'b0, "R2 embedded");
        run_line(66, 1'b1, 3, "R9 embedded out");
        set_mode(1'b0, 1'b1, 1'b0, 64, 1'b1, "R2 embedded wide out");
        run_line(64, 1'b0, 0, "R9 embedded");
        set_mode(1'b0, 1'b0, 1'b0, 32, 1'b1, "R2 back to wide");
        run_line(32, 1'b0, 2, "R5 wide again");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule